// File: doc/BRIEF.md
# Timer with Unbuffered Output Compare

This block is a free-running up-counter that rolls over at a programmable modulo, together with a parameterized set of output compare channels. Each channel holds a 16-bit compare value. In every cycle in which the counter is running and equals that value, the channel drives its pin high, drives it low, toggles it, or leaves it alone, as its action field selects. The match also sets the channel's interrupt flag. The counter sets its own overflow flag each time it rolls over from the modulo back to zero.

Software reaches the block through a byte-wide register port with a write strobe and a combinational read. A new compare value replaces the active one as soon as each byte is written. Nothing holds it back until the next period. A write placed badly within a period can therefore make the channel miss its compare for that period, or fire twice in it. The block reproduces both effects on purpose. Reset leaves the compare values as they were.

Top module: `ocmp_timer`

## Requirements
- R1: After reset the counter reads 0, the counter is stopped, the modulo reads 0xFFFF, and every action field, interrupt enable, interrupt flag, pin and interrupt line is 0.
- R2: The control register at address 0 holds run in bit 0, overflow interrupt enable in bit 1 and the overflow flag in bit 7. The modulo is at addresses 1 (high byte) and 2 (low byte), and the read-only counter is at 3 (high) and 4 (low). While run is 1 the counter advances by one each clock. In a cycle in which it equals the modulo, its next value is 0 and the overflow flag sets, and irq_ovf equals the overflow flag AND its enable. While run is 0 the counter holds its value.
- R3: Channel c has its control byte at address 8+4c, its compare high byte at 9+4c and its compare low byte at 10+4c. The control byte holds the action in bits 1:0, the interrupt enable in bit 2 and the flag in bit 7. A match is a cycle in which run is 1, the counter equals the compare value and no high-byte write is awaiting its low byte. On the clock edge that ends a match cycle, the pin is updated by the action: 00 leaves it, 01 toggles it, 10 clears it and 11 sets it. The pin therefore changes one clock after the counter equals the compare value.
- R4: A match sets the channel flag, and irq_ch[c] equals the channel flag AND the channel's interrupt enable.
- R5: A flag clears only when software writes its register with bit 7 at 0; writing bit 7 as 1 leaves the flag as it is. If a match (or, for the overflow flag, a rollover) happens in the same cycle as the clearing write, the flag stays set.
- R6: Each compare byte write takes effect on the next clock with no buffering. A high-byte write blocks matching on that channel until the low byte is written, and the low-byte write enables matching again.
- R7: If the compare value is rewritten to a value the counter has already passed, while the old value is still ahead of it, no match occurs for the rest of that period.
- R8: If, after a match, the compare value is rewritten to a larger value still ahead of the counter, a second match occurs in the same period.
- R9: Reset does not change the stored compare values; they read back unchanged after reset.
- R10: A pin changes only on the clock after a match on its own channel. With action 00 a match leaves the pin unchanged but still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | DATA_W | Write data byte |
| rdata | output | DATA_W | Read data for addr, combinational |
| oc_pin | output | NCH | Output compare pins, one per channel |
| irq_ch | output | NCH | Channel interrupt requests |
| irq_ovf | output | 1 | Counter overflow interrupt request |

## Verification
The assertions assume three things about the inputs: reset is asserted before the first clock, software cannot load the counter, and every write reaches the block only through wr_en with a known address. Given these, the counter changes only by counting or by rolling over, and a pin changes only after a match. The random stimulus keeps each modulo high byte at zero and draws small modulo values, so rollovers happen often. It mostly keeps compare high bytes at zero, so matches fall inside each period, and sometimes leaves a high byte waiting for its low byte so that matching stays blocked for a while. Directed sequences stop the counter at known values and then rewrite compare values mid-period, to produce the missed-compare and doubled-compare cases.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_action_e;

  // register addresses
  localparam int REG_CTRL   = 0;
  localparam int REG_MOD_HI = 1;
  localparam int REG_MOD_LO = 2;
  localparam int REG_CNT_HI = 3;
  localparam int REG_CNT_LO = 4;
  localparam int CH_BASE    = 8;
  localparam int CH_STRIDE  = 4;
  localparam int CH_CTRL    = 0;
  localparam int CH_CMP_HI  = 1;
  localparam int CH_CMP_LO  = 2;

  // bit positions inside control bytes
  localparam int BIT_RUN  = 0;
  localparam int BIT_OVIE = 1;
  localparam int BIT_IE   = 2;
  localparam int BIT_FLAG = 7;

  function automatic int ch_reg_addr(int ch, int ofs);
    return CH_BASE + CH_STRIDE * ch + ofs;
  endfunction

  // pin value after a match under the given action
  function automatic logic apply_action(oc_action_e act, logic cur);
    case (act)
      ACT_TOGGLE: return !cur;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction

  // sticky flag: an event in the same cycle beats a clearing write
  function automatic logic flag_next(logic cur, logic evt, logic clr);
    return evt | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ocmp_counter.sv
module ocmp_counter
  import ocmp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_mod_hi,
  input  logic              wr_mod_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  modulo_q,
  output logic              run_q,
  output logic              ovie_q,
  output logic              ovf_flag_q,
  output logic              ovf_evt
);

  function automatic logic [CNT_W-1:0] count_step(logic [CNT_W-1:0] cnt, logic wrap);
    return wrap ? '0 : cnt + 1'b1;
  endfunction

  assign ovf_evt = run_q && (count_q == modulo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      modulo_q   <= '1;
      run_q      <= 1'b0;
      ovie_q     <= 1'b0;
      ovf_flag_q <= 1'b0;
    end else begin
      if (run_q) count_q <= count_step(count_q, ovf_evt);
      if (wr_mod_hi) modulo_q[CNT_W-1:DATA_W] <= wdata;
      if (wr_mod_lo) modulo_q[DATA_W-1:0]     <= wdata;
      if (wr_ctrl) begin
        run_q  <= wdata[BIT_RUN];
        ovie_q <= wdata[BIT_OVIE];
      end
      ovf_flag_q <= flag_next(ovf_flag_q, ovf_evt, wr_ctrl && !wdata[BIT_FLAG]);
    end
  end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CNT_W-1:0]  count,
  input  logic              wr_ctrl,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [1:0]        act_q,
  output logic              ie_q,
  output logic              flag_q,
  output logic              pend_q,
  output logic              pin_q,
  output logic              match_evt
);

  function automatic logic is_match(logic en, logic pend, logic [CNT_W-1:0] cnt,
                                    logic [CNT_W-1:0] cmp);
    return en && !pend && (cnt == cmp);
  endfunction

  assign match_evt = is_match(run, pend_q, count, cmp_q);

  // compare value: no reset, each byte lands at once
  always_ff @(posedge clk) begin
    if (wr_hi) cmp_q[CNT_W-1:DATA_W] <= wdata;
    if (wr_lo) cmp_q[DATA_W-1:0]     <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= ACT_NONE;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (match_evt) pin_q <= apply_action(oc_action_e'(act_q), pin_q);
      flag_q <= flag_next(flag_q, match_evt, wr_ctrl && !wdata[BIT_FLAG]);
      if (wr_ctrl) begin
        act_q <= wdata[1:0];
        ie_q  <= wdata[BIT_IE];
      end
      if (wr_lo)      pend_q <= 1'b0;
      else if (wr_hi) pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ocmp_rdmux.sv
module ocmp_rdmux
  import ocmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        run,
  input  logic                        ovie,
  input  logic                        ovf_flag,
  input  logic [CNT_W-1:0]            modulo,
  input  logic [CNT_W-1:0]            count,
  input  logic [NCH-1:0][1:0]         ch_act,
  input  logic [NCH-1:0]              ch_ie,
  input  logic [NCH-1:0]              ch_flag,
  input  logic [NCH-1:0][CNT_W-1:0]   ch_cmp,
  output logic [DATA_W-1:0]           rdata
);

  function automatic logic [DATA_W-1:0] pack_ch_ctrl(logic [1:0] act, logic ie, logic flag);
    logic [DATA_W-1:0] v;
    v           = '0;
    v[1:0]      = act;
    v[BIT_IE]   = ie;
    v[BIT_FLAG] = flag;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] pack_main_ctrl(logic r, logic ie, logic flag);
    logic [DATA_W-1:0] v;
    v           = '0;
    v[BIT_RUN]  = r;
    v[BIT_OVIE] = ie;
    v[BIT_FLAG] = flag;
    return v;
  endfunction

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(REG_CTRL))   rdata = pack_main_ctrl(run, ovie, ovf_flag);
    if (addr == ADDR_W'(REG_MOD_HI)) rdata = modulo[CNT_W-1:DATA_W];
    if (addr == ADDR_W'(REG_MOD_LO)) rdata = modulo[DATA_W-1:0];
    if (addr == ADDR_W'(REG_CNT_HI)) rdata = count[CNT_W-1:DATA_W];
    if (addr == ADDR_W'(REG_CNT_LO)) rdata = count[DATA_W-1:0];
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(ch_reg_addr(c, CH_CTRL)))
        rdata = pack_ch_ctrl(ch_act[c], ch_ie[c], ch_flag[c]);
      if (addr == ADDR_W'(ch_reg_addr(c, CH_CMP_HI)))
        rdata = ch_cmp[c][CNT_W-1:DATA_W];
      if (addr == ADDR_W'(ch_reg_addr(c, CH_CMP_LO)))
        rdata = ch_cmp[c][DATA_W-1:0];
    end
  end

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocmp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    oc_pin,
  output logic [NCH-1:0]    irq_ch,
  output logic              irq_ovf
);

  localparam int CNT_W = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_MOD_HI = ADDR_W'(REG_MOD_HI);
  localparam logic [ADDR_W-1:0] A_MOD_LO = ADDR_W'(REG_MOD_LO);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] modulo_q;
  logic             run_q;
  logic             ovie_q;
  logic             ovf_flag_q;
  logic             ovf_evt;

  logic [NCH-1:0][CNT_W-1:0] ch_cmp;
  logic [NCH-1:0][1:0]       ch_act;
  logic [NCH-1:0]            ch_ie;
  logic [NCH-1:0]            ch_flag;
  logic [NCH-1:0]            ch_pending;
  logic [NCH-1:0]            match_evt;

  logic wr_ctrl, wr_mod_hi, wr_mod_lo;
  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_mod_hi = wr_en && (addr == A_MOD_HI);
  assign wr_mod_lo = wr_en && (addr == A_MOD_LO);

  ocmp_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_mod_hi  (wr_mod_hi),
    .wr_mod_lo  (wr_mod_lo),
    .wdata      (wdata),
    .count_q    (count_q),
    .modulo_q   (modulo_q),
    .run_q      (run_q),
    .ovie_q     (ovie_q),
    .ovf_flag_q (ovf_flag_q),
    .ovf_evt    (ovf_evt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CH_CTRL = ADDR_W'(ch_reg_addr(c, CH_CTRL));
    localparam logic [ADDR_W-1:0] A_CH_HI   = ADDR_W'(ch_reg_addr(c, CH_CMP_HI));
    localparam logic [ADDR_W-1:0] A_CH_LO   = ADDR_W'(ch_reg_addr(c, CH_CMP_LO));

    ocmp_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .count     (count_q),
      .wr_ctrl   (wr_en && (addr == A_CH_CTRL)),
      .wr_hi     (wr_en && (addr == A_CH_HI)),
      .wr_lo     (wr_en && (addr == A_CH_LO)),
      .wdata     (wdata),
      .cmp_q     (ch_cmp[c]),
      .act_q     (ch_act[c]),
      .ie_q      (ch_ie[c]),
      .flag_q    (ch_flag[c]),
      .pend_q    (ch_pending[c]),
      .pin_q     (oc_pin[c]),
      .match_evt (match_evt[c])
    );
  end

  ocmp_rdmux #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
    .addr     (addr),
    .run      (run_q),
    .ovie     (ovie_q),
    .ovf_flag (ovf_flag_q),
    .modulo   (modulo_q),
    .count    (count_q),
    .ch_act   (ch_act),
    .ch_ie    (ch_ie),
    .ch_flag  (ch_flag),
    .ch_cmp   (ch_cmp),
    .rdata    (rdata)
  );

  assign irq_ch  = ch_flag & ch_ie;
  assign irq_ovf = ovf_flag_q & ovie_q;

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_q,
  input logic                ovf_evt,
  input logic                ovf_flag_q,
  input logic [CNT_W-1:0]    count_q,
  input logic [NCH-1:0]      match_evt,
  input logic [NCH-1:0]      ch_pending,
  input logic [NCH-1:0]      ch_flag,
  input logic [NCH-1:0][1:0] ch_act,
  input logic [NCH-1:0]      oc_pin
);

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count_q == '0) && ovf_flag_q) else $error("overflow did not wrap"); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !ovf_evt |=> (count_q - $past(count_q)) == CNT_W'(1)) else $error("count step"); // R2

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(count_q)) else $error("stopped counter moved"); // R2

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_PIN_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !match_evt[c] |=> $stable(oc_pin[c])) else $error("pin moved without match"); // R10

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[c] |=> ch_flag[c]) else $error("match left flag clear"); // R4

    AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[c] && (ch_act[c] == 2'b01) |=> oc_pin[c] != $past(oc_pin[c]))
      else $error("toggle missing"); // R3

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[c] && (ch_act[c] == 2'b11) |=> oc_pin[c]) else $error("set missing"); // R3

    AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt[c] && (ch_act[c] == 2'b10) |=> !oc_pin[c]) else $error("clear missing"); // R3

    AST_PENDING_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pending[c] |-> !match_evt[c]) else $error("match while high byte pending"); // R6
  end

endmodule

bind ocmp_timer ocmp_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .ovf_evt    (ovf_evt),
  .ovf_flag_q (ovf_flag_q),
  .count_q    (count_q),
  .match_evt  (match_evt),
  .ch_pending (ch_pending),
  .ch_flag    (ch_flag),
  .ch_act     (ch_act),
  .oc_pin     (oc_pin)
);

// File: tb/sim_ocmp_timer.sv
`timescale 1ns/1ps
module sim_ocmp_timer;

  localparam int NCH    = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr  = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [NCH-1:0]    oc_pin;
  logic [NCH-1:0]    irq_ch;
  logic              irq_ovf;

  ocmp_timer #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .oc_pin(oc_pin), .irq_ch(irq_ch), .irq_ovf(irq_ovf)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model, from the requirements ----------------
  logic [15:0] m_cnt, m_mod;
  logic        m_run, m_ovie, m_ovf;
  logic [15:0] m_cmp  [NCH];
  logic        m_pend [NCH];
  logic [1:0]  m_act  [NCH];
  logic        m_ie   [NCH];
  logic        m_flag [NCH];
  logic        m_pin  [NCH];
  logic        m_hit  [NCH];
  logic        m_wrap;
  int          ma;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mod = 16'hFFFF; m_run = 0; m_ovie = 0; m_ovf = 0;
      for (int c = 0; c < NCH; c++) begin
        m_pend[c] = 0; m_act[c] = 0; m_ie[c] = 0; m_flag[c] = 0; m_pin[c] = 0;
      end
    end else begin
      ma = wr_en ? int'(addr) : -1;
      m_wrap = m_run && (m_cnt == m_mod);
      for (int c = 0; c < NCH; c++)
        m_hit[c] = m_run && !m_pend[c] && (m_cnt == m_cmp[c]);
      if (m_run) m_cnt = m_wrap ? 16'd0 : m_cnt + 16'd1;
      if (m_wrap) m_ovf = 1;
      else if (ma == 0 && !wdata[7]) m_ovf = 0;
      if (ma == 0) begin m_run = wdata[0]; m_ovie = wdata[1]; end
      if (ma == 1) m_mod[15:8] = wdata;
      if (ma == 2) m_mod[7:0]  = wdata;
      for (int c = 0; c < NCH; c++) begin
        if (m_hit[c]) begin
          case (m_act[c])
            2'b01: m_pin[c] = !m_pin[c];
            2'b10: m_pin[c] = 0;
            2'b11: m_pin[c] = 1;
            default: ;
          endcase
          m_flag[c] = 1;
        end else if (ma == 8 + 4*c && !wdata[7]) m_flag[c] = 0;
        if (ma == 8 + 4*c) begin m_act[c] = wdata[1:0]; m_ie[c] = wdata[2]; end
        if (ma == 9 + 4*c) begin m_cmp[c][15:8] = wdata; m_pend[c] = 1; end
        if (ma == 10 + 4*c) begin m_cmp[c][7:0] = wdata; m_pend[c] = 0; end
      end
    end
  end

  function automatic logic [7:0] model_rd(int a);
    logic [7:0] v = 8'h00;
    if (a == 0) begin v[0] = m_run; v[1] = m_ovie; v[7] = m_ovf; end
    if (a == 1) v = m_mod[15:8];
    if (a == 2) v = m_mod[7:0];
    if (a == 3) v = m_cnt[15:8];
    if (a == 4) v = m_cnt[7:0];
    for (int c = 0; c < NCH; c++) begin
      if (a == 8 + 4*c) begin v[1:0] = m_act[c]; v[2] = m_ie[c]; v[7] = m_flag[c]; end
      if (a == 9 + 4*c)  v = m_cmp[c][15:8];
      if (a == 10 + 4*c) v = m_cmp[c][7:0];
    end
    return v;
  endfunction

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr16(int a_hi, int v);
    wr(a_hi, (v >> 8) & 8'hFF);
    wr(a_hi + 1, v & 8'hFF);
  endtask

  task automatic rd(int a, output int v);
    wr_en = 1'b0; addr = ADDR_W'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic rd_cnt(output int v);
    int h, l;
    rd(3, h); rd(4, l);
    v = (h << 8) | l;
  endtask

  task automatic wait_pin(int c, logic val);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (oc_pin[c] == val) return;
    end
  endtask

  task automatic wait_ovf();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq_ovf) return;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int v, c0, p;
    int wr_addrs[9]  = '{0, 1, 2, 8, 9, 10, 12, 13, 14};
    int rd_addrs[11] = '{0, 1, 2, 3, 4, 8, 9, 10, 12, 13, 14};
    void'($urandom(32'd4177));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v);  chk("R1 ctrl", v, 0);
    rd(1, v);  chk("R1 mod hi", v, 8'hFF);
    rd(2, v);  chk("R1 mod lo", v, 8'hFF);
    rd_cnt(v); chk("R1 count", v, 0);
    rd(8, v);  chk("R1 ch0 ctrl", v, 0);
    chk("R1 pins/irqs", {irq_ovf, irq_ch, oc_pin}, 0);

    // R2/R3/R4 basic operation, modulo 9
    wr16(1, 9);
    wr(8, 8'h07);  wr16(9, 3);    // ch0: ie, set
    wr(12, 8'h05); wr16(13, 5);   // ch1: ie, toggle
    wr(0, 8'h03);
    wait_pin(0, 1'b1);
    rd_cnt(v); chk("R3 set pin one clock after match", v, 4);
    chk("R4 irq_ch0 after match", irq_ch[0], 1);
    wait_pin(1, 1'b1);
    rd_cnt(v); chk("R3 toggle pin one clock after match", v, 6);
    wait_ovf();
    rd_cnt(v); chk("R2 wrap to 0 with overflow irq", v, 0);
    @(negedge clk);
    rd_cnt(v); chk("R2 count step", v, 1);
    wait_pin(1, 1'b0);
    rd_cnt(v); chk("R3 toggle back in next period", v, 6);
    wr(0, 8'h82);                 // stop, keep ovf flag
    chk("R5 writing flag bit 1 keeps overflow flag", irq_ovf, 1);
    rd_cnt(c0); @(negedge clk); @(negedge clk);
    rd_cnt(v); chk("R2 stopped counter holds", v, c0);

    // R10 action 00
    wr(12, 8'h04);
    p = oc_pin[1];
    wr(0, 8'h83);
    repeat (12) @(negedge clk);
    wr(0, 8'h82);
    chk("R10 action none leaves pin", oc_pin[1], p);
    chk("R10 action none still flags", irq_ch[1], 1);

    // R5 flag clearing
    wr(8, 8'h87); chk("R5 write 1 keeps ch flag", irq_ch[0], 1);
    wr(8, 8'h07); chk("R5 write 0 clears ch flag", irq_ch[0], 0);
    wr(0, 8'h02); chk("R5 write 0 clears ovf flag", irq_ovf, 0);
    rd_cnt(c0);
    wr16(9, c0);
    wr(0, 8'h03); wr(8, 8'h07); wr(0, 8'h02);
    chk("R5 match beats same-cycle clear", irq_ch[0], 1);

    // R6 high byte blocks matching until low byte
    wr16(1, 200);
    rd_cnt(c0);
    wr(8, 8'h05); wr16(9, c0 + 3);
    wr(9, 0);
    wr(0, 8'h03); repeat (8) @(negedge clk); wr(0, 8'h02);
    chk("R6 no match while high byte pending", irq_ch[0], 0);
    rd_cnt(c0);
    wr(10, c0 + 3);
    wr(0, 8'h03); repeat (8) @(negedge clk); wr(0, 8'h02);
    chk("R6 low byte re-enables match", irq_ch[0], 1);

    // R7 missed compare
    rd_cnt(c0);
    wr(8, 8'h05); wr16(9, c0 + 6);
    wr(0, 8'h03);
    wr16(9, c0 - 2);
    repeat (10) @(negedge clk);
    wr(0, 8'h02);
    chk("R7 compare missed this period", irq_ch[0], 0);

    // R8 doubled compare
    rd_cnt(c0);
    wr(8, 8'h05); wr16(9, c0 + 1);
    p = oc_pin[0];
    wr(0, 8'h03);
    repeat (3) @(negedge clk);
    chk("R8 first match toggled", oc_pin[0], p ^ 1);
    rd_cnt(v);
    wr16(9, v + 8);
    repeat (12) @(negedge clk);
    wr(0, 8'h02);
    chk("R8 second match in same period", oc_pin[0], p);
    rd_cnt(v); chk("R8 no wrap during test", (v < 200) ? 1 : 0, 1);

    // R9 compare survives reset
    wr16(13, 16'hA5C3);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(13, v); chk("R9 cmp hi kept over reset", v, 8'hA5);
    rd(14, v); chk("R9 cmp lo kept over reset", v, 8'hC3);
    rd(12, v); chk("R1 ch ctrl cleared by reset", v, 0);

    // constrained random against the model
    wr16(1, 40); wr16(13, 7); wr16(9, 20);
    wr(0, 8'h03);
    for (int i = 0; i < 3000; i++) begin
      int sel, a, d;
      @(negedge clk);
      wr_en = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        chk("R3 random pin", oc_pin[c], m_pin[c]);
        chk("R4 random irq", irq_ch[c], m_flag[c] & m_ie[c]);
      end
      chk("R2 random irq_ovf", irq_ovf, m_ovf & m_ovie);
      sel = $urandom_range(0, 9);
      if (sel < 3) begin
        a = wr_addrs[$urandom_range(0, 8)];
        d = $urandom_range(0, 255);
        if (a == 0)  d[0] = ($urandom_range(0, 7) != 0);
        if (a == 1)  d = 0;
        if (a == 2)  d = $urandom_range(12, 255);
        if (a == 9 || a == 13) d = ($urandom_range(0, 9) == 0) ? 1 : 0;
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
      end else begin
        a = rd_addrs[$urandom_range(0, 10)];
        rd(a, d);
        chk("R6 random read", d, int'(model_rd(a)));
      end
    end
    @(negedge clk);
    wr_en = 1'b0;

    finish_run();
  end

endmodule